// File: doc/BRIEF.md
# Supervisor Control and Fault Register Pair

This block holds two byte-wide registers of a supply supervisor. A serial bus front end delivers single-byte register writes to it. One register sets the watchdog interval, the power-on reset delay and the upper-half block protection. The other records which monitored source failed.

Configuration changes are guarded by two volatile enable latches and a three-write unlock sequence: 02h, then 06h, then the new value. Every write takes effect when the transfer's stop condition arrives. A transfer that carries more than one data byte is refused and commits nothing.

The fault register uses active-low flags. Software presets them to 1, and a strobe from the monitoring logic drops the matching flag to 0. Reads are combinational and leave the unlock state untouched.

Top module: `supv_regfile`

## Requirements
- R1: After reset the control register reads 61h and the fault register reads 00h. The control byte is laid out, bit 7 to bit 0, as reset-delay high bit, watchdog bit 1, watchdog bit 0, block protect, constant 0, register-enable latch, write-enable latch, reset-delay low bit. The reset value is watchdog 11, reset delay 01 and protect 0. `rd_sel`=1 selects the control register and 0 selects the fault register on `rd_data`.
- R2: While the register-enable latch is clear, a control write of 02h sets the write-enable latch and a write of 00h clears it. Any other value changes nothing, except as R3 allows.
- R3: A control write of 06h sets the register-enable latch only when the write-enable latch is already set. The register-enable latch is never set while the write-enable latch is clear.
- R4: While the register-enable latch is set, a control write with bit 2 = 0 loads bits 7, 6:5, 4 and 0 into reset-delay high, watchdog, protect and reset-delay low, and clears the register-enable latch. The write-enable latch is kept.
- R5: While the register-enable latch is set, a control write with bit 2 = 1 leaves the configuration unchanged and keeps the register-enable latch set.
- R6: The first data byte of a transfer is answered with `resp_ack`=1 in the cycle after `byte_valid`. Every later byte in the same transfer is answered with `resp_ack`=0, and the transfer then commits nothing.
- R7: A byte commits only at `xfer_stop`. A new `xfer_start` that arrives before the stop discards the pending byte.
- R8: A `prot_hit` strobe clears the register-enable latch in the next cycle.
- R9: Reading either register between the steps of the unlock sequence does not break the sequence.
- R10: A fault-register write needs neither latch. It loads data bits 7, 6 and 4; the other bits read 0.
- R11: `flt_hit[0]`, `flt_hit[1]` and `flt_hit[2]` clear fault bits 7, 6 and 4 respectively in the next cycle. A strobe overrides a software write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start | input | 1 | Start of a register write transfer |
| xfer_stop | input | 1 | Stop condition that ends the transfer |
| byte_valid | input | 1 | A data byte is delivered this cycle |
| byte_sel | input | 1 | Target register: 1 control, 0 fault |
| byte_data | input | 8 | Data byte |
| resp_valid | output | 1 | Acknowledge response is valid |
| resp_ack | output | 1 | 1 = acknowledge, 0 = refuse |
| rd_sel | input | 1 | Read select: 1 control, 0 fault |
| rd_data | output | 8 | Selected register contents |
| prot_hit | input | 1 | Attempted write to a protected memory block |
| flt_hit | input | 3 | Failure strobes: supply, second monitor, watchdog |
| wd_sel | output | 2 | Watchdog interval select |
| por_sel | output | 2 | Reset delay select |
| blk_prot | output | 1 | Upper-half block protect |
| wel | output | 1 | Write-enable latch |
| rwel | output | 1 | Register-enable latch |

## Verification
The bench sweeps all 256 values as the third unlock step. Values with bit 2 set must hold the configuration; a design that ignored this bit would overwrite the configuration with garbage. It also sweeps all 256 values as a lone write with both latches clear. A design that decoded keys loosely, or let 06h in without the write-enable latch, would open the lock there.

Two-byte transfers and restarts without a stop are driven to catch designs that commit early or commit a refused byte. Fault strobes are held across a same-cycle software preset, so a design with the wrong priority would leave a stale 1 in the flag.

// File: rtl/supv_regs_pkg.sv
package supv_regs_pkg;

    localparam int BYTE_W   = 8;
    localparam int NUM_FLT  = 3;
    localparam int HOLD_BIT = 2;

    localparam logic [BYTE_W-1:0] KEY_WEL  = 8'h02;
    localparam logic [BYTE_W-1:0] KEY_RWEL = 8'h06;
    localparam logic [BYTE_W-1:0] KEY_LOCK = 8'h00;

    typedef enum logic {
        SEL_FAULT = 1'b0,
        SEL_CTRL  = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic       pup_hi;
        logic [1:0] wd;
        logic       bp;
        logic       pup_lo;
    } cfg_t;

    localparam cfg_t CFG_RST = '{pup_hi: 1'b0, wd: 2'b11, bp: 1'b0, pup_lo: 1'b1};

    typedef struct packed {
        logic              valid;
        reg_sel_e          sel;
        logic [BYTE_W-1:0] data;
    } commit_t;

    function automatic cfg_t unpack_cfg(logic [BYTE_W-1:0] d);
        cfg_t c;
        c.pup_hi = d[7];
        c.wd     = d[6:5];
        c.bp     = d[4];
        c.pup_lo = d[0];
        return c;
    endfunction

    function automatic logic [BYTE_W-1:0] pack_ctrl(cfg_t c, logic rw, logic we);
        return {c.pup_hi, c.wd, c.bp, 1'b0, rw, we, c.pup_lo};
    endfunction

    // Bit position of each fault flag in the fault byte
    function automatic int flt_pos(int i);
        case (i)
            0:       return 7;
            1:       return 6;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/supv_xfer_track.sv
module supv_xfer_track
    import supv_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_start,
    input  logic              xfer_stop,
    input  logic              byte_valid,
    input  logic              byte_sel,
    input  logic [BYTE_W-1:0] byte_data,
    output commit_t           commit,
    output logic              resp_valid,
    output logic              resp_ack
);
    localparam logic [1:0] CNT_NONE = 2'd0;
    localparam logic [1:0] CNT_ONE  = 2'd1;
    localparam logic [1:0] CNT_OVER = 2'd2;

    logic [1:0]        cnt;
    reg_sel_e          p_sel;
    logic [BYTE_W-1:0] p_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= CNT_NONE;
            p_sel      <= SEL_FAULT;
            p_data     <= '0;
            resp_valid <= 1'b0;
            resp_ack   <= 1'b0;
            commit     <= '0;
        end else begin
            resp_valid   <= byte_valid;
            resp_ack     <= byte_valid && (cnt == CNT_NONE);
            commit.valid <= xfer_stop && !xfer_start && (cnt == CNT_ONE);
            commit.sel   <= p_sel;
            commit.data  <= p_data;
            if (xfer_start) begin
                cnt <= CNT_NONE;
            end else if (byte_valid) begin
                if (cnt == CNT_NONE) begin
                    cnt    <= CNT_ONE;
                    p_sel  <= reg_sel_e'(byte_sel);
                    p_data <= byte_data;
                end else begin
                    cnt <= CNT_OVER;
                end
            end else if (xfer_stop) begin
                cnt <= CNT_NONE;
            end
        end
    end

    AST_EXTRA_BYTE_NACK: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && !xfer_start && cnt != CNT_NONE) |=> (resp_valid && !resp_ack)); // R6

    AST_COMMIT_NEEDS_STOP: assert property (@(posedge clk) disable iff (rst)
        commit.valid |-> $past(xfer_stop)); // R7

endmodule

// File: rtl/supv_ctrl_reg.sv
module supv_ctrl_reg
    import supv_regs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  commit_t commit,
    input  logic    prot_hit,
    output cfg_t    cfg,
    output logic    wel,
    output logic    rwel
);
    logic ctrl_wr;
    assign ctrl_wr = commit.valid && (commit.sel == SEL_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg  <= CFG_RST;
            wel  <= 1'b0;
            rwel <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                if (rwel) begin
                    if (!commit.data[HOLD_BIT]) begin
                        cfg  <= unpack_cfg(commit.data);
                        rwel <= 1'b0;
                    end
                end else if (commit.data == KEY_WEL) begin
                    wel <= 1'b1;
                end else if (commit.data == KEY_RWEL) begin
                    if (wel) rwel <= 1'b1;
                end else if (commit.data == KEY_LOCK) begin
                    wel <= 1'b0;
                end
            end
            if (prot_hit) rwel <= 1'b0;
        end
    end

    AST_RWEL_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
        rwel |-> wel); // R3

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
        !(ctrl_wr && rwel) |=> $stable(cfg)); // R4

    AST_HOLD_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && rwel && commit.data[HOLD_BIT] && !prot_hit) |=> (rwel && $stable(cfg))); // R5

    AST_PROT_CLEARS_RWEL: assert property (@(posedge clk) disable iff (rst)
        prot_hit |=> !rwel); // R8

endmodule

// File: rtl/supv_fault_reg.sv
module supv_fault_reg
    import supv_regs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  commit_t            commit,
    input  logic [NUM_FLT-1:0] flt_hit,
    output logic [NUM_FLT-1:0] flt_q
);
    logic flt_wr;
    assign flt_wr = commit.valid && (commit.sel == SEL_FAULT);

    for (genvar g = 0; g < NUM_FLT; g++) begin : g_flag
        localparam int POS = flt_pos(g);

        always_ff @(posedge clk) begin
            if (rst)             flt_q[g] <= 1'b0;
            else if (flt_hit[g]) flt_q[g] <= 1'b0;
            else if (flt_wr)     flt_q[g] <= commit.data[POS];
        end

        AST_STROBE_CLEARS: assert property (@(posedge clk) disable iff (rst)
            flt_hit[g] |=> !flt_q[g]); // R11
    end

endmodule

// File: rtl/supv_regfile.sv
module supv_regfile
    import supv_regs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               xfer_start,
    input  logic               xfer_stop,
    input  logic               byte_valid,
    input  logic               byte_sel,
    input  logic [BYTE_W-1:0]  byte_data,
    output logic               resp_valid,
    output logic               resp_ack,
    input  logic               rd_sel,
    output logic [BYTE_W-1:0]  rd_data,
    input  logic               prot_hit,
    input  logic [NUM_FLT-1:0] flt_hit,
    output logic [1:0]         wd_sel,
    output logic [1:0]         por_sel,
    output logic               blk_prot,
    output logic               wel,
    output logic               rwel
);
    commit_t            commit;
    cfg_t               cfg;
    logic [NUM_FLT-1:0] flt_q;
    logic [BYTE_W-1:0]  flt_byte;

    supv_xfer_track u_track (
        .clk        (clk),
        .rst        (rst),
        .xfer_start (xfer_start),
        .xfer_stop  (xfer_stop),
        .byte_valid (byte_valid),
        .byte_sel   (byte_sel),
        .byte_data  (byte_data),
        .commit     (commit),
        .resp_valid (resp_valid),
        .resp_ack   (resp_ack)
    );

    supv_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .commit   (commit),
        .prot_hit (prot_hit),
        .cfg      (cfg),
        .wel      (wel),
        .rwel     (rwel)
    );

    supv_fault_reg u_fault (
        .clk     (clk),
        .rst     (rst),
        .commit  (commit),
        .flt_hit (flt_hit),
        .flt_q   (flt_q)
    );

    always_comb begin
        flt_byte = '0;
        for (int i = 0; i < NUM_FLT; i++) flt_byte[flt_pos(i)] = flt_q[i];
    end

    assign rd_data  = rd_sel ? pack_ctrl(cfg, rwel, wel) : flt_byte;
    assign wd_sel   = cfg.wd;
    assign por_sel  = {cfg.pup_hi, cfg.pup_lo};
    assign blk_prot = cfg.bp;

    AST_FAULT_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!rd_sel) |-> (rd_data[5] == 1'b0 && rd_data[3:0] == 4'h0)); // R10

endmodule

// File: tb/tb_supv_regfile.sv
`timescale 1ns/1ps
module tb_supv_regfile;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       xfer_start = 1'b0, xfer_stop = 1'b0, byte_valid = 1'b0, byte_sel = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       resp_valid, resp_ack;
    logic       rd_sel = 1'b1;
    logic [7:0] rd_data;
    logic       prot_hit = 1'b0;
    logic [2:0] flt_hit = 3'b000;
    logic [1:0] wd_sel, por_sel;
    logic       blk_prot, wel, rwel;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    // Reference model state
    logic [1:0] m_wd;
    logic [1:0] m_pup;
    logic       m_bp, m_wel, m_rwel;
    logic [7:0] m_flt;

    supv_regfile dut (
        .clk(clk), .rst(rst), .xfer_start(xfer_start), .xfer_stop(xfer_stop),
        .byte_valid(byte_valid), .byte_sel(byte_sel), .byte_data(byte_data),
        .resp_valid(resp_valid), .resp_ack(resp_ack), .rd_sel(rd_sel), .rd_data(rd_data),
        .prot_hit(prot_hit), .flt_hit(flt_hit), .wd_sel(wd_sel), .por_sel(por_sel),
        .blk_prot(blk_prot), .wel(wel), .rwel(rwel)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_ctrl();
        return {m_pup[1], m_wd, m_bp, 1'b0, m_rwel, m_wel, m_pup[0]};
    endfunction

    task automatic model_write(logic sel, logic [7:0] d);
        if (!sel) begin
            m_flt = d & 8'hD0;
        end else if (m_rwel) begin
            if (!d[2]) begin
                m_pup = {d[7], d[0]}; m_wd = d[6:5]; m_bp = d[4]; m_rwel = 1'b0;
            end
        end else if (d == 8'h02) m_wel = 1'b1;
        else if (d == 8'h06) begin if (m_wel) m_rwel = 1'b1; end
        else if (d == 8'h00) m_wel = 1'b0;
    endtask

    task automatic rd(logic sel, output logic [7:0] v);
        rd_sel = sel;
        #1 v = rd_data;
    endtask

    // One transfer of nbytes data bytes; acks checked per byte
    task automatic wr(logic sel, logic [7:0] d, int nbytes);
        @(negedge clk) xfer_start = 1'b1;
        @(negedge clk) xfer_start = 1'b0;
        for (int k = 0; k < nbytes; k++) begin
            byte_valid = 1'b1; byte_sel = sel; byte_data = d;
            @(negedge clk) byte_valid = 1'b0;
            chk(k == 0 ? "R6 first byte ack" : "R6 extra byte nack",
                {6'd0, resp_valid, resp_ack}, (k == 0) ? 8'h03 : 8'h02);
            @(negedge clk);
        end
        xfer_stop = 1'b1;
        @(negedge clk) xfer_stop = 1'b0;
        repeat (2) @(negedge clk);
        if (nbytes == 1) model_write(sel, d);
    endtask

    task automatic pulse_prot();
        @(negedge clk) prot_hit = 1'b1;
        @(negedge clk) prot_hit = 1'b0;
        m_rwel = 1'b0;
    endtask

    logic [7:0] v;

    initial begin
        m_wd = 2'b11; m_pup = 2'b01; m_bp = 1'b0; m_wel = 1'b0; m_rwel = 1'b0; m_flt = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset values and read select
        rd(1'b1, v); chk("R1 control reset", v, 8'h61);
        rd(1'b0, v); chk("R1 fault reset", v, 8'h00);
        chk("R1 outputs", {wd_sel, por_sel, blk_prot, wel, rwel, 1'b0}, {2'b11, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0});

        // R2 set and clear write-enable
        wr(1'b1, 8'h02, 1); rd(1'b1, v); chk("R2 02h sets WEL", v, exp_ctrl());
        wr(1'b1, 8'h00, 1); rd(1'b1, v); chk("R2 00h clears WEL", v, exp_ctrl());

        // R3 06h without WEL ignored, with WEL sets RWEL
        wr(1'b1, 8'h06, 1); rd(1'b1, v); chk("R3 06h w/o WEL ignored", v, 8'h61);
        wr(1'b1, 8'h02, 1);
        rd(1'b0, v); rd(1'b1, v); // R9 reads between steps
        wr(1'b1, 8'h06, 1);
        rd(1'b0, v); rd(1'b1, v); chk("R3 06h sets RWEL", v, 8'h67);

        // R9 sequence survives reads; complete with a known value
        wr(1'b1, 8'h90, 1); rd(1'b1, v); chk("R9 sequence completes after reads", v, 8'h92);
        chk("R4 outputs", {wd_sel, por_sel, blk_prot, 3'b000}, {2'b00, 2'b10, 1'b1, 3'b000});

        // R2 lone writes with both latches clear: only 02h opens
        for (int x = 0; x < 256; x++) begin
            pulse_prot();
            wr(1'b1, 8'h00, 1);
            wr(1'b1, 8'(x), 1);
            rd(1'b1, v); chk("R2 lone write sweep", v, exp_ctrl());
        end

        // R4 / R5 exhaustive third step
        for (int x = 0; x < 256; x++) begin
            wr(1'b1, 8'h02, 1);
            wr(1'b1, 8'h06, 1);
            wr(1'b1, 8'(x), 1);
            rd(1'b1, v);
            chk(x[2] ? "R5 hold bit keeps config" : "R4 third step loads config", v, exp_ctrl());
            pulse_prot();
        end

        // R8 protect violation clears RWEL
        wr(1'b1, 8'h02, 1); wr(1'b1, 8'h06, 1);
        pulse_prot();
        @(negedge clk); rd(1'b1, v); chk("R8 prot clears RWEL", v, exp_ctrl());
        wr(1'b1, 8'h00, 1); rd(1'b1, v); chk("R8 next write not a third step", v, exp_ctrl());

        // R6 two-byte transfer commits nothing
        wr(1'b1, 8'h02, 1); wr(1'b1, 8'h06, 1);
        wr(1'b1, 8'h10, 2); rd(1'b1, v); chk("R6 two-byte transfer ignored", v, exp_ctrl());

        // R7 restart before stop discards the byte
        @(negedge clk) xfer_start = 1'b1;
        @(negedge clk) xfer_start = 1'b0; byte_valid = 1'b1; byte_sel = 1'b1; byte_data = 8'h10;
        @(negedge clk) byte_valid = 1'b0;
        @(negedge clk) xfer_start = 1'b1;
        @(negedge clk) xfer_start = 1'b0; xfer_stop = 1'b1;
        @(negedge clk) xfer_stop = 1'b0;
        repeat (2) @(negedge clk);
        rd(1'b1, v); chk("R7 restart discards byte", v, exp_ctrl());
        wr(1'b1, 8'h10, 1); rd(1'b1, v); chk("R7 stop commits", v, exp_ctrl());

        // R10 fault register sweep, no latches needed
        pulse_prot(); wr(1'b1, 8'h00, 1);
        for (int x = 0; x < 256; x++) begin
            wr(1'b0, 8'(x), 1);
            rd(1'b0, v); chk("R10 fault write sweep", v, 8'(x) & 8'hD0);
        end

        // R11 each strobe clears its flag
        for (int b = 0; b < 3; b++) begin
            wr(1'b0, 8'hFF, 1);
            @(negedge clk) flt_hit = 3'(1 << b);
            @(negedge clk) flt_hit = 3'b000;
            rd(1'b0, v);
            chk("R11 strobe clears flag", v, (b == 0) ? 8'h50 : (b == 1) ? 8'h90 : 8'hC0);
        end

        // R11 strobe wins over simultaneous preset
        @(negedge clk) xfer_start = 1'b1;
        @(negedge clk) xfer_start = 1'b0; byte_valid = 1'b1; byte_sel = 1'b0; byte_data = 8'hFF;
        @(negedge clk) byte_valid = 1'b0;
        @(negedge clk) xfer_stop = 1'b1; flt_hit = 3'b010;
        @(negedge clk) xfer_stop = 1'b0;
        repeat (3) @(negedge clk);
        flt_hit = 3'b000;
        @(negedge clk);
        rd(1'b0, v); chk("R11 strobe beats preset", v, 8'h90);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule